// File: doc/BRIEF.md
# Bus Parity Error Handler

This block checks parity on a 64-bit multiplexed address/data bus inside a bridge and decides what to do about each error it finds. It captures the bus on every command/address phase and on every data phase in which the bridge receives data. It works out even parity for each 32-bit lane together with that lane's byte-enable (or command) lines. It then compares the result with the lane parity lines, which arrive one clock after the phase. The upper lane is judged only when the phase was 64 bits wide.

A detected error is always logged. Any further reaction is allowed only by a global response enable, and the reaction depends on the kind of phase. An address error can raise interrupts and can abort a cycle that has already been claimed. A bad write-data phase pulls the outgoing PERR# line low. Bad read data is logged as a master error, produces an error completion upstream and pulls PERR# low. While the bridge itself drives write data, it watches the incoming PERR# line. A report against a non-posted write becomes an error completion, and a report against a posted write becomes an interrupt.

Top module: `ppg_top`

## Requirements
- R1: For a phase flagged in cycle N, lane 0 is in error when `bus_par[0]` in cycle N+1 differs from the XOR of `bus_ad[31:0]` and `bus_cbe[3:0]` captured in cycle N. Even parity holds when the XOR of data, enables and parity is 0.
- R2: Lane 1 (`bus_ad[63:32]`, `bus_cbe[7:4]`, `bus_par[1]`) is checked the same way only when `ph_upper` was high with the phase. Otherwise its parity value has no effect on any output.
- R3: Every detected parity error sets `status[0]` in cycle N+2, whatever the enables are. The bit stays set until it is cleared.
- R4: While `cfg_resp_en` is low, a parity error changes only `status[0]`. PERR#, abort, completion, `status[3:1]` and both interrupts stay idle.
- R5: An address-phase error sets `status[2]` (fatal) when `cfg_adr_fatal_en` is set and `status[3]` (non-fatal) when `cfg_adr_nonfatal_en` is set. It pulses `tgt_abort` for one cycle in N+2 when `ph_claimed` was high with the phase.
- R6: A write-data error drives `perr_out_n` low for exactly cycle N+2 and raises no interrupt.
- R7: A read-data error sets `status[1]`, pulses `err_cpl` and drives `perr_out_n` low, all in cycle N+2.
- R8: When `perr_in_n` is low in cycle M+2 after an outbound non-posted write data phase in cycle M, `err_cpl` pulses in cycle M+3.
- R9: When the same happens on a posted write, `status[2]` is set if `cfg_post_fatal_en` is set and `status[3]` if `cfg_post_nonfatal_en` is set, in cycle M+3. `status[0]` is not touched.
- R10: The status bits are write-one-to-clear through `stat_clr`, bit by bit. `irq_fatal` follows `status[2]` and `irq_nonfatal` follows `status[3]` until they are cleared.
- R11: When a set and a clear of the same status bit fall on the same edge, the set wins.
- R12: While reset is asserted, status is zero, `perr_out_n` is high, and `tgt_abort`, `err_cpl` and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_ad | input | 64 | Address/data bus |
| bus_cbe | input | 8 | Command / byte-enable lines |
| bus_par | input | 2 | Lane parity lines, bit 0 lower, bit 1 upper |
| ph_addr | input | 1 | Command/address phase this cycle |
| ph_wr_rx | input | 1 | Write data phase received by the bridge |
| ph_rd_rx | input | 1 | Read data phase received by the bridge |
| ph_upper | input | 1 | Upper lane driven in this phase |
| ph_claimed | input | 1 | Cycle already claimed by decode |
| out_wr_drv | input | 1 | Bridge drives a write data phase |
| out_wr_posted | input | 1 | That outbound write is posted |
| perr_in_n | input | 1 | Incoming PERR#, active low |
| cfg_resp_en | input | 1 | Parity error response enable |
| cfg_adr_fatal_en | input | 1 | Address error fatal enable |
| cfg_adr_nonfatal_en | input | 1 | Address error non-fatal enable |
| cfg_post_fatal_en | input | 1 | Posted write error fatal enable |
| cfg_post_nonfatal_en | input | 1 | Posted write error non-fatal enable |
| stat_clr | input | 4 | Write-one-to-clear strobes for status |
| perr_out_n | output | 1 | Outgoing PERR#, active low |
| tgt_abort | output | 1 | Target abort request pulse |
| err_cpl | output | 1 | Error completion request pulse upstream |
| irq_fatal | output | 1 | Fatal interrupt level |
| irq_nonfatal | output | 1 | Non-fatal interrupt level |
| status | output | 4 | 0 detected, 1 master data error, 2 fatal pending, 3 non-fatal pending |

## Verification
Two events can meet in one cycle: a write-one-to-clear strobe and a new error that sets the same status bit. The bench drives the clear on the very edge where an address parity error lands. It expects the detected and fatal bits to read as set afterwards, and a later clear strobe alone to empty them. A second meeting is an inbound read-data error and a non-posted outbound PERR# report, which both want an error completion. The bench places the two so that their responses fall in the same cycle and checks for a single merged completion pulse with the logging of the read error intact.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;
  typedef enum logic [1:0] {
    PH_NONE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WR_RX = 2'd2,
    PH_RD_RX = 2'd3
  } phase_e;

  localparam int ST_DET   = 0;
  localparam int ST_MDPE  = 1;
  localparam int ST_FATAL = 2;
  localparam int ST_NFAT  = 3;
  localparam int ST_W     = 4;

  typedef struct packed {
    logic addr_err;
    logic wr_err;
    logic rd_err;
    logic claimed;
  } chk_res_t;
endpackage

// File: rtl/ppg_par_check.sv
`timescale 1ns/1ps
module ppg_par_check import ppg_pkg::*; #(
  parameter int DW     = 64,
  parameter int LANE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         ad,
  input  logic [DW/8-1:0]       cbe,
  input  logic                  ph_addr,
  input  logic                  ph_wr,
  input  logic                  ph_rd,
  input  logic                  upper,
  input  logic                  claimed,
  input  logic [DW/LANE_W-1:0]  par_in,
  output chk_res_t              res
);
  localparam int LANES = DW / LANE_W;
  localparam int BE_W  = LANE_W / 8;

  logic [DW-1:0]    ad_q, ad_d;
  logic [DW/8-1:0]  cbe_q, cbe_d;
  phase_e           kind_q, kind_d;
  logic             upper_q, upper_d;
  logic             claimed_q, claimed_d;
  logic             cap_en;
  logic [LANES-1:0] lane_err;
  logic             any_err;

  // capture enable: data registers load only when a phase is flagged
  always_comb begin
    cap_en    = ph_addr | ph_wr | ph_rd;
    ad_d      = ad;
    cbe_d     = cbe;
    upper_d   = upper;
    claimed_d = claimed;
    if (ph_addr)     kind_d = PH_ADDR;
    else if (ph_wr)  kind_d = PH_WR_RX;
    else if (ph_rd)  kind_d = PH_RD_RX;
    else             kind_d = PH_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= PH_NONE;
    end else begin
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      ad_q      <= ad_d;
      cbe_q     <= cbe_d;
      upper_q   <= upper_d;
      claimed_q <= claimed_d;
    end
  end

  // per-lane even parity compare against the late parity line
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic exp_par;
    logic lane_on;
    assign exp_par     = ^{ad_q[g*LANE_W +: LANE_W], cbe_q[g*BE_W +: BE_W]};
    if (g == 0) begin : g_base
      assign lane_on = 1'b1;
    end else begin : g_wide
      assign lane_on = upper_q;
    end
    assign lane_err[g] = lane_on & (exp_par ^ par_in[g]);
  end

  assign any_err = (kind_q != PH_NONE) & (|lane_err);

  always_comb begin
    res.addr_err = any_err & (kind_q == PH_ADDR);
    res.wr_err   = any_err & (kind_q == PH_WR_RX);
    res.rd_err   = any_err & (kind_q == PH_RD_RX);
    res.claimed  = claimed_q;
  end

  // R1: phase strobes are mutually exclusive
  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_addr, ph_wr, ph_rd}));
endmodule

// File: rtl/ppg_perr_sample.sv
`timescale 1ns/1ps
module ppg_perr_sample #(
  parameter int LAT = 2   // cycles from outbound data phase to PERR# sample, >= 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv,
  input  logic posted,
  input  logic perr_in_n,
  output logic hit_posted,
  output logic hit_nonposted
);
  logic [LAT-1:0] v_q, v_d;
  logic [LAT-1:0] p_q, p_d;

  always_comb begin
    v_d = {v_q[LAT-2:0], drv};
    p_d = {p_q[LAT-2:0], drv & posted};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      p_q <= '0;
    end else begin
      v_q <= v_d;
      p_q <= p_d;
    end
  end

  assign hit_posted    = v_q[LAT-1] &  p_q[LAT-1] & ~perr_in_n;
  assign hit_nonposted = v_q[LAT-1] & ~p_q[LAT-1] & ~perr_in_n;

  // R8: a sampled PERR# report must trace back to an outbound data phase
  a_r8_hit_has_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_posted | hit_nonposted) |-> $past(v_q[LAT-2]));
endmodule

// File: rtl/ppg_resp.sv
`timescale 1ns/1ps
module ppg_resp import ppg_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  chk_res_t        res,
  input  logic            hit_posted,
  input  logic            hit_nonposted,
  input  logic            en,
  input  logic            adr_fen,
  input  logic            adr_nfen,
  input  logic            post_fen,
  input  logic            post_nfen,
  input  logic [ST_W-1:0] clr,
  output logic [ST_W-1:0] status,
  output logic            perr_n,
  output logic            abort,
  output logic            cpl
);
  logic [ST_W-1:0] st_q, st_d, st_set;
  logic            perr_q, perr_d;
  logic            abort_q, abort_d;
  logic            cpl_q, cpl_d;
  logic            det;

  always_comb begin
    det              = res.addr_err | res.wr_err | res.rd_err;
    st_set           = '0;
    st_set[ST_DET]   = det;
    st_set[ST_MDPE]  = en & res.rd_err;
    st_set[ST_FATAL] = en & ((res.addr_err & adr_fen)  | (hit_posted & post_fen));
    st_set[ST_NFAT]  = en & ((res.addr_err & adr_nfen) | (hit_posted & post_nfen));
    st_d             = (st_q & ~clr) | st_set;   // set wins over clear
    perr_d           = ~(en & (res.wr_err | res.rd_err));
    abort_d          = en & res.addr_err & res.claimed;
    cpl_d            = en & (res.rd_err | hit_nonposted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      perr_q  <= 1'b1;
      abort_q <= 1'b0;
      cpl_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      perr_q  <= perr_d;
      abort_q <= abort_d;
      cpl_q   <= cpl_d;
    end
  end

  assign status = st_q;
  assign perr_n = perr_q;
  assign abort  = abort_q;
  assign cpl    = cpl_q;

  a_r4_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (perr_n && !abort && !cpl));
  a_r3_det_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_DET] && !clr[ST_DET]) |=> status[ST_DET]);
  a_r5_abort_logged: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> status[ST_DET]);
  a_r7_mdpe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_MDPE]) |-> (cpl && !perr_n));
  a_r10_fatal_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_FATAL]) |-> $past(clr[ST_FATAL]));
endmodule

// File: rtl/ppg_top.sv
`timescale 1ns/1ps
module ppg_top import ppg_pkg::*; #(
  parameter int DW       = 64,
  parameter int LANE_W   = 32,
  parameter int PERR_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        bus_ad,
  input  logic [DW/8-1:0]      bus_cbe,
  input  logic [DW/LANE_W-1:0] bus_par,
  input  logic                 ph_addr,
  input  logic                 ph_wr_rx,
  input  logic                 ph_rd_rx,
  input  logic                 ph_upper,
  input  logic                 ph_claimed,
  input  logic                 out_wr_drv,
  input  logic                 out_wr_posted,
  input  logic                 perr_in_n,
  input  logic                 cfg_resp_en,
  input  logic                 cfg_adr_fatal_en,
  input  logic                 cfg_adr_nonfatal_en,
  input  logic                 cfg_post_fatal_en,
  input  logic                 cfg_post_nonfatal_en,
  input  logic [3:0]           stat_clr,
  output logic                 perr_out_n,
  output logic                 tgt_abort,
  output logic                 err_cpl,
  output logic                 irq_fatal,
  output logic                 irq_nonfatal,
  output logic [3:0]           status
);
  chk_res_t res;
  logic     hit_p, hit_np;

  ppg_par_check #(.DW(DW), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ad(bus_ad), .cbe(bus_cbe),
    .ph_addr(ph_addr), .ph_wr(ph_wr_rx), .ph_rd(ph_rd_rx),
    .upper(ph_upper), .claimed(ph_claimed), .par_in(bus_par), .res(res)
  );

  ppg_perr_sample #(.LAT(PERR_LAT)) u_smp (
    .clk(clk), .rst_n(rst_n), .drv(out_wr_drv), .posted(out_wr_posted),
    .perr_in_n(perr_in_n), .hit_posted(hit_p), .hit_nonposted(hit_np)
  );

  ppg_resp u_resp (
    .clk(clk), .rst_n(rst_n), .res(res), .hit_posted(hit_p),
    .hit_nonposted(hit_np), .en(cfg_resp_en), .adr_fen(cfg_adr_fatal_en),
    .adr_nfen(cfg_adr_nonfatal_en), .post_fen(cfg_post_fatal_en),
    .post_nfen(cfg_post_nonfatal_en), .clr(stat_clr), .status(status),
    .perr_n(perr_out_n), .abort(tgt_abort), .cpl(err_cpl)
  );

  assign irq_fatal    = status[ST_FATAL];
  assign irq_nonfatal = status[ST_NFAT];

  // R10: interrupt levels only drop on a clear strobe
  a_r10_nf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_nonfatal) |-> $past(stat_clr[ST_NFAT]));
endmodule

// File: tb/ppg_top_bench.sv
`timescale 1ns/1ps
module ppg_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] bus_ad;
  logic [7:0]  bus_cbe;
  logic [1:0]  bus_par;
  logic        ph_addr, ph_wr_rx, ph_rd_rx, ph_upper, ph_claimed;
  logic        out_wr_drv, out_wr_posted, perr_in_n;
  logic        cfg_resp_en, cfg_adr_fatal_en, cfg_adr_nonfatal_en;
  logic        cfg_post_fatal_en, cfg_post_nonfatal_en;
  logic [3:0]  stat_clr;
  logic        perr_out_n, tgt_abort, err_cpl, irq_fatal, irq_nonfatal;
  logic [3:0]  status;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ppg_top u_ppg_top (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe(bus_cbe), .bus_par(bus_par),
    .ph_addr(ph_addr), .ph_wr_rx(ph_wr_rx), .ph_rd_rx(ph_rd_rx), .ph_upper(ph_upper),
    .ph_claimed(ph_claimed), .out_wr_drv(out_wr_drv), .out_wr_posted(out_wr_posted),
    .perr_in_n(perr_in_n), .cfg_resp_en(cfg_resp_en), .cfg_adr_fatal_en(cfg_adr_fatal_en),
    .cfg_adr_nonfatal_en(cfg_adr_nonfatal_en), .cfg_post_fatal_en(cfg_post_fatal_en),
    .cfg_post_nonfatal_en(cfg_post_nonfatal_en), .stat_clr(stat_clr),
    .perr_out_n(perr_out_n), .tgt_abort(tgt_abort), .err_cpl(err_cpl),
    .irq_fatal(irq_fatal), .irq_nonfatal(irq_nonfatal), .status(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_ad = '0; bus_cbe = '0; bus_par = '0;
    ph_addr = 0; ph_wr_rx = 0; ph_rd_rx = 0; ph_upper = 0; ph_claimed = 0;
    out_wr_drv = 0; out_wr_posted = 0; perr_in_n = 1;
    stat_clr = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); stat_clr = 4'hF;
    @(negedge clk); stat_clr = 4'h0;
    chk("R10 status cleared", {28'd0, status}, 32'd0);
    chk("R10 irq levels dropped", {30'd0, irq_fatal, irq_nonfatal}, 32'd0);
  endtask

  // kind: 0 address, 1 write data received, 2 read data received
  task automatic run_phase(int kind, bit up, bit clm, bit bad_lo, bit bad_hi,
                           bit e, bit fe, bit nfe, int seed);
    logic [63:0] a;
    logic [7:0]  c;
    bit err, is_a, is_w, is_r;
    logic [3:0] exp_st;
    a = {32'h9E3779B1 * seed[31:0], 32'h85EBCA6B * (seed[31:0] + 32'd7)};
    c = 8'h5A ^ seed[7:0];
    is_a = (kind == 0); is_w = (kind == 1); is_r = (kind == 2);
    @(negedge clk);
    bus_ad = a; bus_cbe = c;
    ph_addr = is_a; ph_wr_rx = is_w; ph_rd_rx = is_r;
    ph_upper = up; ph_claimed = clm;
    cfg_resp_en = e; cfg_adr_fatal_en = fe; cfg_adr_nonfatal_en = nfe;
    cfg_post_fatal_en = 0; cfg_post_nonfatal_en = 0;
    @(negedge clk);
    ph_addr = 0; ph_wr_rx = 0; ph_rd_rx = 0;
    bus_ad = ~a; bus_cbe = ~c;
    bus_par[0] = (^{a[31:0],  c[3:0]}) ^ bad_lo;
    bus_par[1] = (^{a[63:32], c[7:4]}) ^ bad_hi;
    @(negedge clk);
    err = bad_lo | (up & bad_hi);
    exp_st = {e & is_a & err & nfe, e & is_a & err & fe, e & is_r & err, err};
    chk("R1/R2/R3 status after phase", {28'd0, status}, {28'd0, exp_st});
    chk("R4/R6/R7 perr_out_n", {31'd0, perr_out_n}, {31'd0, !(e & err & (is_w | is_r))});
    chk("R5 tgt_abort", {31'd0, tgt_abort}, {31'd0, e & is_a & err & clm});
    chk("R7 err_cpl", {31'd0, err_cpl}, {31'd0, e & is_r & err});
    chk("R10 irq follow status", {30'd0, irq_fatal, irq_nonfatal},
        {30'd0, exp_st[2], exp_st[3]});
    @(negedge clk);
    chk("R6 responses last one cycle", {29'd0, perr_out_n, tgt_abort, err_cpl}, 32'h4);
    bus_par = '0;
    clear_all();
  endtask

  task automatic run_outwr(bit posted, bit bad, bit e, bit fe, bit nfe);
    @(negedge clk);
    cfg_resp_en = e; cfg_post_fatal_en = fe; cfg_post_nonfatal_en = nfe;
    cfg_adr_fatal_en = 1; cfg_adr_nonfatal_en = 1;
    out_wr_drv = 1; out_wr_posted = posted;
    @(negedge clk); out_wr_drv = 0; out_wr_posted = 0;
    @(negedge clk); perr_in_n = !bad;
    @(negedge clk); perr_in_n = 1;
    chk("R8 err_cpl on non-posted report", {31'd0, err_cpl}, {31'd0, e & bad & !posted});
    chk("R9 status after outbound report", {28'd0, status},
        {28'd0, e & bad & posted & nfe, e & bad & posted & fe, 2'b00});
    chk("R9 perr_out_n untouched", {31'd0, perr_out_n}, 32'd1);
    @(negedge clk);
    chk("R8 completion one cycle", {31'd0, err_cpl}, 32'd0);
    clear_all();
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed = 1;
    idle_inputs();
    cfg_resp_en = 1; cfg_adr_fatal_en = 1; cfg_adr_nonfatal_en = 1;
    cfg_post_fatal_en = 1; cfg_post_nonfatal_en = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset status", {28'd0, status}, 32'd0);
    chk("R12 reset outputs", {27'd0, perr_out_n, tgt_abort, err_cpl, irq_fatal, irq_nonfatal},
        32'h10);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 3; k++)
      for (int u = 0; u < 2; u++)
        for (int b = 0; b < 4; b++)
          for (int en = 0; en < 2; en++)
            for (int cl = 0; cl < 2; cl++)
              for (int f = 0; f < 4; f++) begin
                run_phase(k, u[0], cl[0], b[0], b[1], en[0], f[0], f[1], seed);
                seed++;
              end

    for (int p = 0; p < 2; p++)
      for (int bd = 0; bd < 2; bd++)
        for (int en = 0; en < 2; en++)
          for (int f = 0; f < 4; f++)
            run_outwr(p[0], bd[0], en[0], f[0], f[1]);

    // R11: clear strobe on the same edge as a new address error
    @(negedge clk);
    cfg_resp_en = 1; cfg_adr_fatal_en = 1; cfg_adr_nonfatal_en = 0;
    bus_ad = 64'h0123_4567_89AB_CDEF; bus_cbe = 8'h3C; ph_addr = 1; ph_upper = 0;
    @(negedge clk);
    ph_addr = 0;
    bus_par[0] = ~(^{32'h89AB_CDEF, 4'hC});
    stat_clr = 4'hF;
    @(negedge clk);
    stat_clr = 4'h0;
    chk("R11 set wins over clear", {28'd0, status}, 32'h5);
    // R10: clearing only the fatal bit leaves the detected bit
    stat_clr = 4'h4;
    @(negedge clk);
    stat_clr = 4'h0;
    chk("R10 per-bit clear", {28'd0, status}, 32'h1);
    chk("R10 irq_fatal dropped", {31'd0, irq_fatal}, 32'd0);
    clear_all();

    // read-data error and non-posted outbound report merge into one completion
    @(negedge clk);
    out_wr_drv = 1; out_wr_posted = 0;
    @(negedge clk);
    out_wr_drv = 0;
    bus_ad = 64'hFFFF_0000_1111_2222; bus_cbe = 8'h0F; ph_rd_rx = 1; ph_upper = 0;
    @(negedge clk);
    ph_rd_rx = 0; perr_in_n = 0;
    bus_par[0] = ~(^{32'h1111_2222, 4'hF});
    @(negedge clk);
    perr_in_n = 1;
    chk("R7/R8 merged completion", {31'd0, err_cpl}, 32'd1);
    chk("R7 read error logged", {28'd0, status}, 32'h3);
    @(negedge clk);
    chk("R7/R8 single pulse", {31'd0, err_cpl}, 32'd0);
    clear_all();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule